// File: doc/BRIEF.md
# Two-Rank Weighted Bit Counter Cell

This cell adds a small group of single-bit inputs in which some bits carry weight one and the others carry weight two. It returns the weighted total as an unsigned binary number. It is the basic reduction step of a multi-operand adder tree. A column of weight-one dots and the next column of weight-two dots go in, and a short binary word comes out. That word is then spread over the following columns of the next stage. The cell is purely combinational. Every output bit depends on no more than six inputs, so each output bit can be mapped onto one six-input lookup table and the whole cell forms a single logic level.

The shape is set by parameters: `LO_BITS` sets the number of weight-one inputs, `HI_BITS` sets the number of weight-two inputs, and `OUT_W` sets the result width. `OUT_W` defaults to the smallest width that holds `2*HI_BITS + LO_BITS`.

Elaboration rejects any of the following configurations:
- more than six inputs in total;
- an output too narrow to hold the largest total;
- an output with no fewer bits than the inputs, since such a cell gives no reduction;
- exactly one weight-one input, since that input would only pass straight through.

A smaller cell can be obtained from a larger one by tying some of its inputs low. The parameter `USE_TABLE` selects how the result is built:
- 0 builds it from two population counts and a shifted addition;
- 1 builds it from per-output truth tables indexed by the packed inputs, which gives the same result.

Top module: `wbc_cell`

## Requirements
- R1: For the default shape (3 weight-two inputs, 3 weight-one inputs, 4 output bits), `sum_o` equals 2 × (set bits of `hi_i`) + (set bits of `lo_i`) for every input combination, and is never below either term.
- R2: With no weight-two inputs and six weight-one inputs (3 output bits), `sum_o` equals the number of set bits of `lo_i`, as a plain 6:3 counter.
- R3: The shapes (2 weight-two, 3 weight-one; 3 bits) and (1 weight-two, 5 weight-one; 3 bits) return the weighted total for all input combinations.
- R4: Bit 0 of `sum_o` always equals the XOR of all weight-one inputs.
- R5: `sum_o` never exceeds 2 × `HI_BITS` + `LO_BITS`.
- R6: When `HI_BITS` is 0, the single placeholder bit of `hi_i` has no effect on `sum_o`.
- R7: A (2,3;3) cell with `hi_i[1]` held at 0 behaves as a (1,3;3) cell: `sum_o` = 2 × `hi_i[0]` + set bits of `lo_i`.
- R8: The table form (`USE_TABLE`=1) and the arithmetic form (`USE_TABLE`=0) of the same shape give identical `sum_o` for every input.
- R9: All-zero inputs give `sum_o` = 0, and all-ones inputs give the maximum 2 × `HI_BITS` + `LO_BITS` (9 for the default shape).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_i | input | max(LO_BITS,1) | Weight-one input bits; the placeholder bit is ignored when LO_BITS is 0 |
| hi_i | input | max(HI_BITS,1) | Weight-two input bits; the placeholder bit is ignored when HI_BITS is 0 |
| sum_o | output | OUT_W | Weighted total of the inputs, unsigned binary |

## Verification
The immediate assertions inside the cell watch every input change and check four properties:
- the low output bit against the parity of the weight-one inputs;
- the result against its largest legal value;
- the result against each population count that feeds it;
- each population count against the number of inputs it covers.

These checks cannot show that the total is exactly right. Exact values need the bench's exhaustive sweeps, which compare several shapes against an integer model. Only those sweeps can show three further behaviours:
- the two build forms agree;
- the placeholder pin is ignored;
- a smaller cell is realised by tying one input low.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   // largest number of inputs that still fits one lookup-table level
   localparam int unsigned MAX_IN   = 6;
   // width of a population count over at most MAX_IN bits
   localparam int unsigned CNT_W    = 3;
   // width of the internal weighted sum (2*6 = 12 fits 5 bits with headroom)
   localparam int unsigned ACC_W    = 5;
   localparam int unsigned TT_DEPTH = 1 << MAX_IN;

   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((1 << w) <= v) w++;
      return w;
   endfunction

   function automatic int unsigned max_total(input int unsigned hi_n, input int unsigned lo_n);
      return 2 * hi_n + lo_n;
   endfunction

   function automatic int unsigned min_width(input int unsigned hi_n, input int unsigned lo_n);
      return bits_for(max_total(hi_n, lo_n));
   endfunction

   function automatic int unsigned count_field(input int unsigned word,
                                               input int unsigned base,
                                               input int unsigned len);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < len; i++) c += (word >> (base + i)) & 1;
      return c;
   endfunction

   // truth table of output bit `sbit` over the packed index {hi, lo}
   function automatic logic [TT_DEPTH-1:0] table_for(input int unsigned hi_n,
                                                   input int unsigned lo_n,
                                                   input int unsigned sbit);
      logic [TT_DEPTH-1:0] t;
      int unsigned tot;
      t = '0;
      for (int unsigned idx = 0; idx < TT_DEPTH; idx++) begin
         tot = 2 * count_field(idx, lo_n, hi_n) + count_field(idx, 0, lo_n);
         t[idx] = ((tot >> sbit) & 1) != 0;
      end
      return t;
   endfunction

endpackage

// File: rtl/wbc_popcnt.sv
module wbc_popcnt
   import wbc_pkg::*;
#(
   parameter int unsigned N = 3
) (
   input  logic [MAX_IN-1:0] bits_i,
   output logic [CNT_W-1:0]  cnt_o
);

   generate
      if (N == 0) begin : g_empty
         assign cnt_o = '0;
      end else if (N == 1) begin : g_single
         assign cnt_o = CNT_W'(bits_i[0]);
      end else begin : g_multi
         always_comb begin
            cnt_o = '0;
            for (int i = 0; i < MAX_IN; i++) begin
               if (i < int'(N)) cnt_o = cnt_o + CNT_W'(bits_i[i]);
            end
         end
      end
   endgenerate

   // a count can never exceed the number of bits it covers
   always_comb begin
      if (!$isunknown(cnt_o))
         a_r5_count_bound: assert (int'(cnt_o) <= int'(N))
            else $error("count %0d above field size %0d", cnt_o, N);
   end

endmodule

// File: rtl/wbc_arith.sv
module wbc_arith
   import wbc_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [CNT_W-1:0] hi_cnt_i,
   input  logic [CNT_W-1:0] lo_cnt_i,
   output logic [W-1:0]     sum_o
);

   logic [ACC_W-1:0] acc;

   always_comb begin
      acc   = ACC_W'({hi_cnt_i, 1'b0}) + ACC_W'(lo_cnt_i);
      sum_o = acc[W-1:0];
   end

endmodule

// File: rtl/wbc_table.sv
module wbc_table
   import wbc_pkg::*;
#(
   parameter int unsigned HI_N = 3,
   parameter int unsigned LO_N = 3,
   parameter int unsigned W    = 4
) (
   input  logic [MAX_IN-1:0] idx_i,
   output logic [W-1:0]      sum_o
);

   // one six-input function per output bit
   generate
      for (genvar s = 0; s < int'(W); s++) begin : g_bit
         localparam logic [TT_DEPTH-1:0] TT = table_for(HI_N, LO_N, s);
         assign sum_o[s] = TT[idx_i];
      end
   endgenerate

endmodule

// File: rtl/wbc_cell.sv
module wbc_cell
   import wbc_pkg::*;
#(
   parameter int unsigned HI_BITS   = 3,
   parameter int unsigned LO_BITS   = 3,
   parameter int unsigned OUT_W     = min_width(HI_BITS, LO_BITS),
   parameter bit          USE_TABLE = 1'b0,
   localparam int unsigned HI_PW    = (HI_BITS > 0) ? HI_BITS : 1,
   localparam int unsigned LO_PW    = (LO_BITS > 0) ? LO_BITS : 1
) (
   input  logic [LO_PW-1:0] lo_i,
   input  logic [HI_PW-1:0] hi_i,
   output logic [OUT_W-1:0] sum_o
);

   localparam int unsigned TOTAL_IN = HI_BITS + LO_BITS;
   localparam int unsigned MAX_SUM  = max_total(HI_BITS, LO_BITS);
   localparam int unsigned NEED_W   = min_width(HI_BITS, LO_BITS);

   // ---------------- elaboration-time shape checks ----------------
   generate
      if (TOTAL_IN > MAX_IN) begin : g_err_fanin
         $error("wbc_cell: %0d inputs exceed one-level limit %0d", TOTAL_IN, MAX_IN);
      end
      if (OUT_W < NEED_W) begin : g_err_narrow
         $error("wbc_cell: OUT_W %0d cannot hold %0d", OUT_W, MAX_SUM);
      end
      if (OUT_W >= TOTAL_IN) begin : g_err_noreduce
         $error("wbc_cell: %0d outputs for %0d inputs gives no reduction", OUT_W, TOTAL_IN);
      end
      if (LO_BITS == 1) begin : g_err_single
         $error("wbc_cell: a lone weight-one input would only pass through");
      end
   endgenerate

   // ---------------- zero-extended input fields ----------------
   logic [MAX_IN-1:0] lo_ext;
   logic [MAX_IN-1:0] hi_ext;

   generate
      for (genvar i = 0; i < int'(MAX_IN); i++) begin : g_ext
         if (i < int'(LO_BITS)) begin : g_lo_used
            assign lo_ext[i] = lo_i[i];
         end else begin : g_lo_zero
            assign lo_ext[i] = 1'b0;
         end
         if (i < int'(HI_BITS)) begin : g_hi_used
            assign hi_ext[i] = hi_i[i];
         end else begin : g_hi_zero
            assign hi_ext[i] = 1'b0;
         end
      end
   endgenerate

   // population counts (also used by the guards below)
   logic [CNT_W-1:0] lo_cnt;
   logic [CNT_W-1:0] hi_cnt;

   wbc_popcnt #(.N(LO_BITS)) u_lo_cnt (.bits_i(lo_ext), .cnt_o(lo_cnt));
   wbc_popcnt #(.N(HI_BITS)) u_hi_cnt (.bits_i(hi_ext), .cnt_o(hi_cnt));

   // ---------------- variant selection ----------------
   generate
      if (USE_TABLE) begin : g_table
         logic [MAX_IN-1:0] idx;
         always_comb begin
            idx = lo_ext;
            for (int i = 0; i < MAX_IN; i++) begin
               if (i < int'(HI_BITS)) idx[(int'(LO_BITS) + i) % MAX_IN] = hi_ext[i];
            end
         end
         wbc_table #(.HI_N(HI_BITS), .LO_N(LO_BITS), .W(OUT_W)) u_tab (
            .idx_i (idx),
            .sum_o (sum_o)
         );
      end else begin : g_arith
         wbc_arith #(.W(OUT_W)) u_add (
            .hi_cnt_i (hi_cnt),
            .lo_cnt_i (lo_cnt),
            .sum_o    (sum_o)
         );
      end
   endgenerate

   // ---------------- guards ----------------
   always_comb begin
      if (!$isunknown({lo_ext, hi_ext, sum_o})) begin
         a_r4_lsb_parity: assert (sum_o[0] == (^lo_ext))
            else $error("low bit %0b disagrees with weight-one parity", sum_o[0]);
         a_r5_no_overflow: assert (int'(sum_o) <= int'(MAX_SUM))
            else $error("result %0d above maximum %0d", sum_o, MAX_SUM);
         a_r1_hi_floor: assert (int'(sum_o) >= 2 * int'(hi_cnt))
            else $error("result %0d below weight-two part", sum_o);
         a_r1_lo_floor: assert (int'(sum_o) >= int'(lo_cnt))
            else $error("result %0d below weight-one part", sum_o);
      end
   end

endmodule

// File: tb/sim_wbc_cell.sv
module sim_wbc_cell;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   // u0: default (3,3;4) arithmetic; u5: same shape, table form
   logic [2:0] a_lo, a_hi;
   logic [3:0] s0, s5;
   wbc_cell u0 (.lo_i(a_lo), .hi_i(a_hi), .sum_o(s0));
   wbc_cell #(.USE_TABLE(1'b1)) u5 (.lo_i(a_lo), .hi_i(a_hi), .sum_o(s5));

   // u1: (0,6;3) with placeholder weight-two pin
   logic [5:0] b_lo;
   logic [0:0] b_hi;
   logic [2:0] s1;
   wbc_cell #(.HI_BITS(0), .LO_BITS(6)) u1 (.lo_i(b_lo), .hi_i(b_hi), .sum_o(s1));

   // u2/u3: (2,3;3) arithmetic and table
   logic [2:0] c_lo;
   logic [1:0] c_hi;
   logic [2:0] s2, s3;
   wbc_cell #(.HI_BITS(2), .LO_BITS(3)) u2 (.lo_i(c_lo), .hi_i(c_hi), .sum_o(s2));
   wbc_cell #(.HI_BITS(2), .LO_BITS(3), .USE_TABLE(1'b1)) u3 (.lo_i(c_lo), .hi_i(c_hi), .sum_o(s3));

   // u4: (1,5;3) table
   logic [4:0] d_lo;
   logic [0:0] d_hi;
   logic [2:0] s4;
   wbc_cell #(.HI_BITS(1), .LO_BITS(5), .USE_TABLE(1'b1)) u4 (.lo_i(d_lo), .hi_i(d_hi), .sum_o(s4));

   function automatic int ones(input int v);
      int c = 0;
      for (int i = 0; i < 32; i++) c += (v >> i) & 1;
      return c;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input int v, input bit r1_dummy);
      a_lo = v[2:0];  a_hi = v[5:3];
      b_lo = v[5:0];  b_hi = r1_dummy;
      c_lo = v[2:0];  c_hi = v[4:3];
      d_lo = v[4:0];  d_hi = v[5];
   endtask

   initial begin
      drive(0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 reset-state zero u0", s0, 0);
      chk("R9 reset-state zero u1", s1, 0);
      rst = 1'b0;
      for (int pass = 0; pass < 2; pass++) begin
         for (int v = 0; v < 64; v++) begin
            int exp0, exp1, exp2, exp4;
            @(posedge clk);
            #1 drive(v, pass[0] ^ v[0]);
            @(negedge clk);
            exp0 = 2 * ones(v[5:3]) + ones(v[2:0]);
            exp1 = ones(v[5:0]);
            exp2 = 2 * ones(v[4:3]) + ones(v[2:0]);
            exp4 = 2 * int'(v[5]) + ones(v[4:0]);
            chk("R1 default weighted total", s0, exp0);
            chk("R8 table matches arithmetic (3,3;4)", s5, s0);
            chk("R8 table form (3,3;4) vs model", s5, exp0);
            chk("R2 plain 6:3 counter", s1, exp1);
            chk("R6 placeholder pin ignored", s1, exp1);
            chk("R3 (2,3;3) total", s2, exp2);
            chk("R8 table matches arithmetic (2,3;3)", s3, s2);
            chk("R3 (1,5;3) total", s4, exp4);
            chk("R4 low bit is weight-one parity", s0 & 1, ones(v[2:0]) & 1);
            chk("R5 within maximum", (s0 <= 9) ? 1 : 0, 1);
            if (v[4] == 1'b0)
               chk("R7 (1,3;3) on (2,3;3) cell", s2, 2 * int'(v[3]) + ones(v[2:0]));
            if (v == 0)  chk("R9 all-zero gives zero", s0, 0);
            if (v == 63) chk("R9 all-ones gives maximum", s0, 9);
         end
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule